// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller takes a set of interrupt request lines and hands at most one of them at a time to a processor core. Every source resolves to one of five priority tiers. From lowest to highest they are the software tier, then levels 0, 1 and 2, and the top tier 3. A thread running outside any handler sits below all five. The controller keeps the priority of the handler now running. It presents a new request only when that request outranks the running handler, so handlers nest. The core confirms that it has taken a request with an acknowledge pulse and reports the end of a handler with a return pulse. The controller saves and restores the running priority on a small internal stack.

Sources 0 and 1 are fixed at tier 3 and cannot be masked. Sources 2 and 3 are debug sources at tier 3 that need a mask bit. The last source is the software-tier interrupt, which only a register write can raise. Every other source takes its level and its enable bit from software. The presented request carries a vector address: a programmable base plus twice the source number. One fast slot can be pointed at any source, and that source then presents a separate programmed address in place of its table entry. A wake output tells the clock logic that some active request exists, whatever the running priority.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset irq_o, fast_o and wake_o are 0, src_o and vec_o are 0, the ordinary sources are disabled, the debug mask is clear and the vector base is 0.
- R2: A write to address 16+k sets ordinary source k (4 to 14): bit 2 is its enable and bits 1:0 its level (0, 1 or 2; the value 3 acts as level 2). Writes to addresses 16+k for sources 0 to 3 and 15 have no effect.
- R3: Among active sources the highest tier wins, and within a tier the lowest source number wins. The result appears on the outputs one clock after the inputs change.
- R4: Sources 0 and 1 are tier 3 and always active while their line is high. Debug sources 2 and 3 are tier 3 and are active only while bit (k-2) of the mask register at address 4 is 1.
- R5: Source 15 is the software tier. Writing 1 to bit 0 of address 3 makes it pending, and its acknowledge clears it. Line irq_i[15] is ignored.
- R6: The tier order is thread < software < 0 < 1 < 2 < 3. A request is presented only when its tier is strictly above the running tier.
- R7: Acknowledging a presented request saves the running tier on a 4-entry stack and makes the granted tier the running tier. rti_i restores the saved tier. While the stack is full, no request is presented. rti_i on an empty stack leaves the thread tier in place.
- R8: If ack_i and rti_i arrive in the same cycle, the granted tier becomes the running tier and the stack is left unchanged.
- R9: vec_o equals the base register (address 0) plus two times src_o, modulo 2^16.
- R10: Address 2 holds the fast source number in bits 3:0 and the fast enable in bit 15. Address 1 holds the fast address. While the fast source is enabled and presented, vec_o shows the fast address and fast_o is 1.
- R11: wake_o is 1 one clock after any source is active, even when the running tier blocks it.
- R12: ack_i while irq_o is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write address |
| reg_wdata | input | 16 | Register write data |
| irq_i | input | 16 | Request lines, one per source |
| ack_i | input | 1 | Core accepts the presented request |
| rti_i | input | 1 | Core returns from the running handler |
| irq_o | output | 1 | A request is presented |
| src_o | output | 4 | Number of the presented source |
| vec_o | output | 16 | Vector address of the presented source |
| fast_o | output | 1 | The presented source uses the fast slot |
| wake_o | output | 1 | Some source is active |

## Verification
An acknowledge and a return can fall in the same cycle, which is the case of a handler ending just as a new one is accepted. The bench provokes it by driving both pulses on one clock while a level-1 request preempts a level-0 handler. It judges the result through the presented requests that follow. A level-0 request must stay blocked at first, and after a single return it must appear, because the software tier was restored. If the stack were pushed and then popped, or popped and then pushed, the bench would see a different order.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

    typedef logic [2:0] rank_t;

    localparam rank_t RANK_NONE = 3'd0;
    localparam rank_t RANK_SW   = 3'd1;
    localparam rank_t RANK_L0   = 3'd2;
    localparam rank_t RANK_L1   = 3'd3;
    localparam rank_t RANK_L2   = 3'd4;
    localparam rank_t RANK_L3   = 3'd5;

    localparam int ADR_BASE  = 0;
    localparam int ADR_FADDR = 1;
    localparam int ADR_FCTL  = 2;
    localparam int ADR_SWTRG = 3;
    localparam int ADR_DMASK = 4;

    function automatic rank_t level_to_rank(input logic [1:0] lvl);
        case (lvl)
            2'd0:    return RANK_L0;
            2'd1:    return RANK_L1;
            default: return RANK_L2;
        endcase
    endfunction

endpackage

// File: rtl/nest_irq_cfg.sv
module nest_irq_cfg
    import nest_irq_pkg::*;
#(
    parameter int NSRC   = 16,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16,
    parameter int REG_AW = 5,
    parameter int NFIXED = 2,
    parameter int NDBG   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [REG_AW-1:0]      waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   sw_clr_i,
    output logic [DATA_W-1:0]      base_o,
    output logic [DATA_W-1:0]      fast_addr_o,
    output logic [IDX_W-1:0]       fast_src_o,
    output logic                   fast_en_o,
    output logic [NDBG-1:0]        dbg_mask_o,
    output logic [NSRC-1:0]        src_en_o,
    output logic [NSRC-1:0][1:0]   src_lvl_o,
    output logic                   sw_pend_o
);

    localparam int CFG_OFS  = 1 << (REG_AW - 1);
    localparam int ORD_LO   = NFIXED + NDBG;
    localparam int SW_IDX   = NSRC - 1;

    typedef struct packed {
        logic [DATA_W-1:0]    base;
        logic [DATA_W-1:0]    faddr;
        logic [IDX_W-1:0]     fsrc;
        logic                 fen;
        logic [NDBG-1:0]      dmask;
        logic [NSRC-1:0]      en;
        logic [NSRC-1:0][1:0] lvl;
        logic                 swp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sw_clr_i) begin
            cfg_d.swp = 1'b0;
        end
        if (we) begin
            if (waddr == REG_AW'(ADR_BASE)) begin
                cfg_d.base = wdata;
            end
            if (waddr == REG_AW'(ADR_FADDR)) begin
                cfg_d.faddr = wdata;
            end
            if (waddr == REG_AW'(ADR_FCTL)) begin
                cfg_d.fsrc = wdata[IDX_W-1:0];
                cfg_d.fen  = wdata[DATA_W-1];
            end
            if (waddr == REG_AW'(ADR_SWTRG) && wdata[0]) begin
                cfg_d.swp = 1'b1;
            end
            if (waddr == REG_AW'(ADR_DMASK)) begin
                cfg_d.dmask = wdata[NDBG-1:0];
            end
            for (int k = ORD_LO; k < SW_IDX; k++) begin
                if (waddr == REG_AW'(CFG_OFS + k)) begin
                    cfg_d.en[k]  = wdata[2];
                    cfg_d.lvl[k] = wdata[1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign base_o      = cfg_q.base;
    assign fast_addr_o = cfg_q.faddr;
    assign fast_src_o  = cfg_q.fsrc;
    assign fast_en_o   = cfg_q.fen;
    assign dbg_mask_o  = cfg_q.dmask;
    assign src_en_o    = cfg_q.en;
    assign src_lvl_o   = cfg_q.lvl;
    assign sw_pend_o   = cfg_q.swp;

endmodule

// File: rtl/nest_irq_rank_map.sv
module nest_irq_rank_map
    import nest_irq_pkg::*;
#(
    parameter int NSRC   = 16,
    parameter int NFIXED = 2,
    parameter int NDBG   = 2
) (
    input  logic [NSRC-1:0]        irq_i,
    input  logic [NSRC-1:0]        src_en_i,
    input  logic [NSRC-1:0][1:0]   src_lvl_i,
    input  logic [NDBG-1:0]        dbg_mask_i,
    input  logic                   sw_pend_i,
    output rank_t [NSRC-1:0]       rank_o
);

    localparam int ORD_LO = NFIXED + NDBG;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        if (k < NFIXED) begin : g_fixed
            assign rank_o[k] = irq_i[k] ? RANK_L3 : RANK_NONE;
        end else if (k < ORD_LO) begin : g_dbg
            assign rank_o[k] = (irq_i[k] && dbg_mask_i[k-NFIXED]) ? RANK_L3 : RANK_NONE;
        end else if (k == NSRC - 1) begin : g_sw
            assign rank_o[k] = sw_pend_i ? RANK_SW : RANK_NONE;
        end else begin : g_ord
            assign rank_o[k] = (irq_i[k] && src_en_i[k]) ? level_to_rank(src_lvl_i[k]) : RANK_NONE;
        end
    end

endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
    import nest_irq_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int IDX_W = 4
) (
    input  rank_t [NSRC-1:0]   rank_i,
    output rank_t              best_rank_o,
    output logic [IDX_W-1:0]   best_idx_o
);

    always_comb begin
        best_rank_o = RANK_NONE;
        best_idx_o  = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (rank_i[k] != RANK_NONE && rank_i[k] >= best_rank_o) begin
                best_rank_o = rank_i[k];
                best_idx_o  = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nest_irq_pkg::*;
#(
    parameter int NSRC        = 16,
    parameter int DATA_W      = 16,
    parameter int REG_AW      = 5,
    parameter int NFIXED      = 2,
    parameter int NDBG        = 2,
    parameter int STACK_DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    input  logic [NSRC-1:0]               irq_i,
    input  logic                          ack_i,
    input  logic                          rti_i,
    output logic                          irq_o,
    output logic [$clog2(NSRC)-1:0]       src_o,
    output logic [DATA_W-1:0]             vec_o,
    output logic                          fast_o,
    output logic                          wake_o
);

    localparam int IDX_W = $clog2(NSRC);
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);
    localparam int SW_IDX = NSRC - 1;

    typedef struct packed {
        rank_t                         cur;
        rank_t [STACK_DEPTH-1:0]       stk;
        logic [CNT_W-1:0]              cnt;
        logic                          irq;
        logic [IDX_W-1:0]              src;
        rank_t                         rank;
        logic [DATA_W-1:0]             vec;
        logic                          fast;
        logic                          wake;
    } st_t;

    st_t st_d, st_q;

    logic [DATA_W-1:0]     base;
    logic [DATA_W-1:0]     fast_addr;
    logic [IDX_W-1:0]      fast_src;
    logic                  fast_en;
    logic [NDBG-1:0]       dbg_mask;
    logic [NSRC-1:0]       src_en;
    logic [NSRC-1:0][1:0]  src_lvl;
    logic                  sw_pend;
    logic                  sw_clr;
    rank_t [NSRC-1:0]      src_rank;
    rank_t                 best_rank;
    logic [IDX_W-1:0]      best_idx;
    logic                  take;
    logic                  pop;

    logic [CNT_W-1:0]      stk_cnt;
    rank_t                 cur_rank;

    nest_irq_cfg #(
        .NSRC(NSRC), .IDX_W(IDX_W), .DATA_W(DATA_W),
        .REG_AW(REG_AW), .NFIXED(NFIXED), .NDBG(NDBG)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .waddr       (reg_addr),
        .wdata       (reg_wdata),
        .sw_clr_i    (sw_clr),
        .base_o      (base),
        .fast_addr_o (fast_addr),
        .fast_src_o  (fast_src),
        .fast_en_o   (fast_en),
        .dbg_mask_o  (dbg_mask),
        .src_en_o    (src_en),
        .src_lvl_o   (src_lvl),
        .sw_pend_o   (sw_pend)
    );

    nest_irq_rank_map #(
        .NSRC(NSRC), .NFIXED(NFIXED), .NDBG(NDBG)
    ) u_map (
        .irq_i      (irq_i),
        .src_en_i   (src_en),
        .src_lvl_i  (src_lvl),
        .dbg_mask_i (dbg_mask),
        .sw_pend_i  (sw_pend),
        .rank_o     (src_rank)
    );

    nest_irq_arbiter #(
        .NSRC(NSRC), .IDX_W(IDX_W)
    ) u_arb (
        .rank_i      (src_rank),
        .best_rank_o (best_rank),
        .best_idx_o  (best_idx)
    );

    assign take   = ack_i && st_q.irq;
    assign pop    = rti_i && (st_q.cnt != '0);
    assign sw_clr = take && (st_q.src == IDX_W'(SW_IDX));

    always_comb begin
        st_d = st_q;

        if (take && pop) begin
            st_d.cur = st_q.rank;
        end else if (take) begin
            for (int i = 0; i < STACK_DEPTH; i++) begin
                if (st_q.cnt == CNT_W'(i)) begin
                    st_d.stk[i] = st_q.cur;
                end
            end
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.cur = st_q.rank;
        end else if (pop) begin
            for (int i = 0; i < STACK_DEPTH; i++) begin
                if (st_q.cnt == CNT_W'(i + 1)) begin
                    st_d.cur = st_q.stk[i];
                end
            end
            st_d.cnt = st_q.cnt - 1'b1;
        end

        st_d.irq  = (best_rank > st_d.cur) && (st_d.cnt < CNT_W'(STACK_DEPTH));
        st_d.src  = '0;
        st_d.rank = RANK_NONE;
        st_d.vec  = '0;
        st_d.fast = 1'b0;
        if (st_d.irq) begin
            st_d.src  = best_idx;
            st_d.rank = best_rank;
            if (fast_en && fast_src == best_idx) begin
                st_d.vec  = fast_addr;
                st_d.fast = 1'b1;
            end else begin
                st_d.vec = base + DATA_W'({best_idx, 1'b0});
            end
        end
        st_d.wake = (best_rank != RANK_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o    = st_q.irq;
    assign src_o    = st_q.src;
    assign vec_o    = st_q.vec;
    assign fast_o   = st_q.fast;
    assign wake_o   = st_q.wake;
    assign stk_cnt  = st_q.cnt;
    assign cur_rank = st_q.cur;

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk
    import nest_irq_pkg::*;
#(
    parameter int NSRC        = 16,
    parameter int STACK_DEPTH = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              ack_i,
    input logic                              rti_i,
    input logic                              irq_o,
    input logic [$clog2(NSRC)-1:0]           src_o,
    input logic                              fast_o,
    input logic                              wake_o,
    input logic [$clog2(STACK_DEPTH+1)-1:0]  stk_cnt,
    input rank_t                             cur_rank
);

    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    p_fast_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fast_o |-> irq_o);

    p_wake_covers_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);

    p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_cnt == CNT_W'(STACK_DEPTH)) |-> !irq_o);

    p_empty_is_thread_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_cnt == '0) |-> (cur_rank == RANK_NONE));

    p_ack_retires_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> !(irq_o && src_o == $past(src_o)));

    p_idle_keeps_stack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rti_i && !(ack_i && irq_o)) |=> $stable(stk_cnt));

    p_pair_keeps_stack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_i && ack_i && irq_o && stk_cnt != '0) |=> $stable(stk_cnt));

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
    .NSRC(NSRC), .STACK_DEPTH(STACK_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_i    (ack_i),
    .rti_i    (rti_i),
    .irq_o    (irq_o),
    .src_o    (src_o),
    .fast_o   (fast_o),
    .wake_o   (wake_o),
    .stk_cnt  (stk_cnt),
    .cur_rank (cur_rank)
);

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] irq_i = '0;
    logic        ack_i = 1'b0;
    logic        rti_i = 1'b0;
    logic        irq_o;
    logic [3:0]  src_o;
    logic [15:0] vec_o;
    logic        fast_o;
    logic        wake_o;

    int total = 0;
    int bad = 0;
    logic [15:0] base_v = 16'h1000;

    always #2.5 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .irq_i(irq_i), .ack_i(ack_i), .rti_i(rti_i),
        .irq_o(irq_o), .src_o(src_o), .vec_o(vec_o), .fast_o(fast_o),
        .wake_o(wake_o)
    );

    // {irq lines, expected irq_o, expected src}
    localparam logic [20:0] TBL [10] = '{
        {16'h0000, 1'b0, 4'd0},
        {16'h0010, 1'b1, 4'd4},
        {16'h0030, 1'b1, 4'd5},
        {16'h00C0, 1'b1, 4'd6},
        {16'h0100, 1'b0, 4'd0},
        {16'h0210, 1'b1, 4'd4},
        {16'h0004, 1'b0, 4'd0},
        {16'h0041, 1'b1, 4'd0},
        {16'h0003, 1'b1, 4'd0},
        {16'h8000, 1'b0, 4'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input logic a, input logic r);
        @(negedge clk);
        ack_i = a; rti_i = r;
        @(negedge clk);
        ack_i = 1'b0; rti_i = 1'b0;
        settle();
    endtask

    task automatic drive(input logic [15:0] v);
        irq_i = v;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq", irq_o, 0);
        chk("R1 wake", wake_o, 0);
        chk("R1 vec", vec_o, 0);
        chk("R1 src", src_o, 0);
        chk("R1 fast", fast_o, 0);
        rst_n = 1'b1;
        drive(16'h0010);
        chk("R1 disabled after reset", irq_o, 0);
        drive(16'h0000);

        wr(5'd0, base_v);
        wr(5'd20, 16'h4);
        wr(5'd21, 16'h5);
        wr(5'd22, 16'h6);
        wr(5'd23, 16'h7);
        wr(5'd24, 16'h1);
        wr(5'd25, 16'h4);

        // R3 table walk
        for (int i = 0; i < 10; i++) begin
            drive(TBL[i][20:5]);
            chk("R3 irq", irq_o, TBL[i][4]);
            if (TBL[i][4]) begin
                chk("R3 src", src_o, TBL[i][3:0]);
                chk("R9 vec", vec_o, base_v + 16'(2 * TBL[i][3:0]));
                chk("R10 fast idle", fast_o, 0);
            end
        end

        // R2 ignored config writes
        wr(5'd16, 16'h0);
        wr(5'd31, 16'h4);
        drive(16'h8001);
        chk("R2 fixed source stays", src_o, 0);
        chk("R2 fixed source irq", irq_o, 1);
        drive(16'h8000);
        chk("R5 line 15 ignored", irq_o, 0);
        chk("R11 no wake", wake_o, 0);

        // R4 debug mask
        wr(5'd4, 16'h1);
        drive(16'h0004);
        chk("R4 dbg unmasked", src_o, 2);
        chk("R4 dbg irq", irq_o, 1);
        drive(16'h0008);
        chk("R4 dbg still masked", irq_o, 0);

        // R10 fast slot
        wr(5'd2, 16'h8005);
        wr(5'd1, 16'hABC0);
        drive(16'h0020);
        chk("R10 fast vec", vec_o, 16'hABC0);
        chk("R10 fast flag", fast_o, 1);
        drive(16'h0010);
        chk("R10 other src vec", vec_o, 16'h1008);
        chk("R10 other src flag", fast_o, 0);
        wr(5'd2, 16'h0005);
        drive(16'h0020);
        chk("R10 fast disabled", vec_o, 16'h100A);

        // R9 wrap
        wr(5'd0, 16'hFFF0);
        drive(16'h0200);
        chk("R9 wrap", vec_o, 16'h0002);
        wr(5'd0, base_v);
        drive(16'h0000);

        // R5 software tier, R12, R6, R7 nesting
        wr(5'd3, 16'h1);
        settle();
        chk("R5 sw pending", src_o, 15);
        chk("R5 sw irq", irq_o, 1);
        pulse(1'b1, 1'b0);
        chk("R5 sw cleared by ack", irq_o, 0);
        pulse(1'b1, 1'b0);
        drive(16'h0200);
        chk("R12 ack ignored, L0 above sw", src_o, 9);
        pulse(1'b1, 1'b0);
        drive(16'h0210);
        chk("R6 equal tier blocked", irq_o, 0);
        drive(16'h0020);
        chk("R6 L1 preempts L0", src_o, 5);
        pulse(1'b1, 1'b0);
        drive(16'h0040);
        chk("R6 L2 preempts L1", src_o, 6);
        pulse(1'b1, 1'b0);
        drive(16'h0041);
        chk("R7 full stack blocks", irq_o, 0);
        chk("R11 wake while blocked", wake_o, 1);
        pulse(1'b0, 1'b1);
        chk("R7 pop reopens", src_o, 0);
        chk("R7 pop irq", irq_o, 1);
        drive(16'h0000);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        drive(16'h0200);
        chk("R7 restored sw tier", src_o, 9);
        drive(16'h0000);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        wr(5'd3, 16'h1);
        settle();
        chk("R7 empty pop keeps thread", src_o, 15);

        // R8 ack and return together
        pulse(1'b1, 1'b0);
        drive(16'h0200);
        pulse(1'b1, 1'b0);
        drive(16'h0020);
        chk("R8 L1 presented", src_o, 5);
        pulse(1'b1, 1'b1);
        drive(16'h0200);
        chk("R8 running tier is L1", irq_o, 0);
        pulse(1'b0, 1'b1);
        chk("R8 stack kept sw tier", src_o, 9);
        chk("R8 irq", irq_o, 1);
        drive(16'h0100);
        chk("R11 disabled no wake", wake_o, 0);
        drive(16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule